// File: doc/BRIEF.md
# Multilevel Cell Write-and-Verify Programming Controller

This controller programs a single phase-change cell to one of four resistance levels. A start strobe hands it a 2-bit level code. The two extreme levels are written open loop, each with one fixed pulse. Level 0 gets a short, high-current rectangular amorphizing pulse. Level 3 gets a crystallizing pulse with a long trailing ramp. Levels 1 and 2 are written closed loop. The first partial-melt pulse uses a per-level starting current code. After every pulse the controller asks for a verify read and receives an 8-bit read-current sample. It compares the sample with a per-level target and a shared tolerance, and it corrects the current code in proportion to the error. The loop ends when the sample falls inside the window or when an iteration budget runs out.

Pulses go to an external pulse generator as a request stream. Each request carries a pulse kind, a current code and a width. Verify reads use a request stream and a response stream. All three are valid/ready. Back-pressure rules:
- A request raised by the controller stays up with frozen fields until the consumer takes it.
- A response is only consumed while `rd_rsp_ready` is high. The controller raises it only while it waits for the read that belongs to the latest pulse.

Configuration inputs are sampled on the accepted start, and status is plain: `busy`, a one-cycle `done`, `fail` and the pulse count.

Top module: `mlc_prog_ctrl`

## Requirements
- R1: Level 0 issues exactly one pulse of kind 0 (rectangular amorphizing), current code RST_CODE (default 255), width RST_W (default 4), no verify read, then finishes with fail 0 and pulse count 1.
- R2: Level 3 issues exactly one pulse of kind 1 (ramped crystallizing), current code SET_CODE (default 40), width SET_W (default 60), no verify read, then finishes with fail 0 and pulse count 1.
- R3: Levels 1 and 2 issue pulses of kind 2 (partial melt) with width MELT_W (default 8). The first pulse carries that level's starting code (`lvl1_init` or `lvl2_init`), and every pulse is followed by exactly one verify read request.
- R4: A verify sample inside [target − margin, target + margin] ends the run with fail 0. The bounds are clipped to 0 and 255, so target 3 with margin 6 accepts 0..9.
- R5: A sample above the window raises the current code by max(1, (sample − target) >> `gain_shift`), saturating at 2^CW − 1. A sample below the window lowers it by max(1, (target − sample) >> `gain_shift`), saturating at 0.
- R6: When the verify of pulse number N misses the window and N equals the iteration limit, the run ends with fail 1. The limit is `max_iter`, or 16 when `max_iter` is 0.
- R7: `iter_count` equals the number of pulses accepted in the last run and holds that value until the next accepted start.
- R8: A pulse or read request held without ready keeps its valid and all its fields unchanged. Pulse and read requests never overlap.
- R9: A start while `busy` is high is ignored: the run in progress finishes with the level, configuration and results of its own start.
- R10: `done` is high for exactly one cycle per run. `busy` is high from the cycle after an accepted start up to, but not including, the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, taken only when idle |
| target_lvl | input | 2 | Level code 0..3 to program |
| lvl1_tgt | input | DW | Verify target code for level 1 |
| lvl2_tgt | input | DW | Verify target code for level 2 |
| tol_margin | input | DW | Half-width of the acceptance window |
| lvl1_init | input | CW | Starting current code for level 1 |
| lvl2_init | input | CW | Starting current code for level 2 |
| gain_shift | input | 3 | Right shift applied to the error |
| max_iter | input | ITW | Pulse budget, 0 selects 16 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion strobe |
| fail | output | 1 | Last run hit the budget without converging |
| iter_count | output | ITW | Pulses issued in the last run |
| pls_valid | output | 1 | Pulse request valid |
| pls_ready | input | 1 | Pulse generator accepts the request |
| pls_kind | output | 2 | 0 amorphizing, 1 crystallizing, 2 partial melt |
| pls_current | output | CW | Pulse current code |
| pls_width | output | WW | Pulse width in generator ticks |
| rd_req_valid | output | 1 | Verify read request valid |
| rd_req_ready | input | 1 | Read path accepts the request |
| rd_rsp_valid | input | 1 | Verify sample valid |
| rd_rsp_ready | output | 1 | Controller waiting for a sample |
| rd_rsp_data | input | DW | Digitized read current |

## Verification
The embedded properties assume well-behaved peers. They assume the pulse and read consumers eventually raise ready. They assume a read response appears only after its request was taken, and that configuration inputs are steady while start is asserted. The bench keeps to this. Its pulse and read-request consumers toggle ready on alternate cycles, so requests are sometimes stalled. Its cell model returns one sample, two cycles after each accepted read request, computed from the last pulse current as 200 minus the code (floored at 0). Configuration changes only between runs. The one deliberate out-of-turn input is a start strobe with a different level raised while a run is busy.

// File: rtl/mlc_prog_pkg.sv
package mlc_prog_pkg;

  typedef enum logic [1:0] {
    PK_AMORPH = 2'd0,
    PK_CRYST  = 2'd1,
    PK_MELT   = 2'd2
  } pulse_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_RDREQ = 2'd2,
    ST_WAIT  = 2'd3
  } ctrl_state_e;

  localparam int GS_W = 3;

endpackage

// File: rtl/mlc_level_sel.sv
module mlc_level_sel
  import mlc_prog_pkg::*;
#(
  parameter int CW       = 8,
  parameter int DW       = 8,
  parameter int WW       = 8,
  parameter int RST_CODE = 255,
  parameter int SET_CODE = 40,
  parameter int RST_W    = 4,
  parameter int SET_W    = 60,
  parameter int MELT_W   = 8
) (
  input  logic [1:0]    level,
  input  logic [DW-1:0] l1_tgt,
  input  logic [DW-1:0] l2_tgt,
  input  logic [CW-1:0] l1_init,
  input  logic [CW-1:0] l2_init,
  output pulse_kind_e   kind,
  output logic [CW-1:0] code,
  output logic [WW-1:0] width,
  output logic          inner,
  output logic [DW-1:0] tgt
);

  localparam logic [CW-1:0] RST_C = CW'(RST_CODE);
  localparam logic [CW-1:0] SET_C = CW'(SET_CODE);
  localparam logic [WW-1:0] RST_P = WW'(RST_W);
  localparam logic [WW-1:0] SET_P = WW'(SET_W);
  localparam logic [WW-1:0] MLT_P = WW'(MELT_W);

  always_comb begin
    inner = 1'b0;
    kind  = PK_MELT;
    code  = l1_init;
    width = MLT_P;
    tgt   = l1_tgt;
    unique case (level)
      2'd0: begin
        kind  = PK_AMORPH;
        code  = RST_C;
        width = RST_P;
      end
      2'd3: begin
        kind  = PK_CRYST;
        code  = SET_C;
        width = SET_P;
      end
      2'd1: begin
        inner = 1'b1;
        code  = l1_init;
        tgt   = l1_tgt;
      end
      default: begin
        inner = 1'b1;
        code  = l2_init;
        tgt   = l2_tgt;
      end
    endcase
  end

endmodule

// File: rtl/mlc_step_calc.sv
module mlc_step_calc
  import mlc_prog_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic [CW-1:0]   cur_code,
  input  logic [DW-1:0]   sample,
  input  logic [DW-1:0]   tgt,
  input  logic [DW-1:0]   margin,
  input  logic [GS_W-1:0] shift,
  output logic            in_win,
  output logic [CW-1:0]   next_code
);

  localparam int SW = ((CW > DW) ? CW : DW) + 1;
  localparam logic [SW-1:0] CMAX = {{(SW-CW){1'b0}}, {CW{1'b1}}};

  logic [DW:0]   hi_sum;
  logic [DW-1:0] lo_b, hi_b, diff, shifted;
  logic          above, below;
  logic [SW-1:0] step, cur_x, up, dn;

  always_comb begin
    hi_sum  = {1'b0, tgt} + {1'b0, margin};
    lo_b    = (tgt >= margin) ? (tgt - margin) : '0;
    hi_b    = hi_sum[DW] ? '1 : hi_sum[DW-1:0];
    above   = sample > hi_b;
    below   = sample < lo_b;
    in_win  = !above && !below;
    diff    = above ? (sample - tgt) : (tgt - sample);
    shifted = diff >> shift;
    step    = (shifted == '0) ? SW'(1) : {{(SW-DW){1'b0}}, shifted};
    cur_x   = {{(SW-CW){1'b0}}, cur_code};
    up      = cur_x + step;
    if (up > CMAX) up = CMAX;
    dn      = (step > cur_x) ? '0 : (cur_x - step);
    if (above)      next_code = up[CW-1:0];
    else if (below) next_code = dn[CW-1:0];
    else            next_code = cur_code;
  end

  // R5: correction moves in the direction of the error and never wraps
  always_comb begin
    if (!$isunknown({cur_code, sample, tgt, margin, shift})) begin
      if (above) a_r5_raise_no_wrap: assert (next_code >= cur_code);
      if (below) a_r5_lower_no_wrap: assert (next_code <= cur_code);
    end
  end

endmodule

// File: rtl/mlc_iter_ctr.sv
module mlc_iter_ctr #(
  parameter int ITW      = 6,
  parameter int DEF_ITER = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           inc,
  input  logic [ITW-1:0] limit_in,
  output logic [ITW-1:0] count,
  output logic           at_limit
);

  localparam logic [ITW-1:0] DEF_L = ITW'(DEF_ITER);

  logic [ITW-1:0] eff_limit;

  assign eff_limit = (limit_in == '0) ? DEF_L : limit_in;
  assign at_limit  = count >= eff_limit;

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  // R6: a run never issues more pulses than its budget
  a_r6_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= eff_limit);

  // R7: the count only moves on clear or pulse acceptance
  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(count));

endmodule

// File: rtl/mlc_prog_ctrl.sv
module mlc_prog_ctrl
  import mlc_prog_pkg::*;
#(
  parameter int CW       = 8,
  parameter int DW       = 8,
  parameter int WW       = 8,
  parameter int ITW      = 6,
  parameter int DEF_ITER = 16,
  parameter int RST_CODE = 255,
  parameter int SET_CODE = 40,
  parameter int RST_W    = 4,
  parameter int SET_W    = 60,
  parameter int MELT_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      target_lvl,
  input  logic [DW-1:0]   lvl1_tgt,
  input  logic [DW-1:0]   lvl2_tgt,
  input  logic [DW-1:0]   tol_margin,
  input  logic [CW-1:0]   lvl1_init,
  input  logic [CW-1:0]   lvl2_init,
  input  logic [GS_W-1:0] gain_shift,
  input  logic [ITW-1:0]  max_iter,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [ITW-1:0]  iter_count,
  output logic            pls_valid,
  input  logic            pls_ready,
  output logic [1:0]      pls_kind,
  output logic [CW-1:0]   pls_current,
  output logic [WW-1:0]   pls_width,
  output logic            rd_req_valid,
  input  logic            rd_req_ready,
  input  logic            rd_rsp_valid,
  output logic            rd_rsp_ready,
  input  logic [DW-1:0]   rd_rsp_data
);

  ctrl_state_e     state;
  pulse_kind_e     sel_kind, kind_q;
  logic [CW-1:0]   sel_code, code_q, nxt_code;
  logic [WW-1:0]   sel_width, width_q;
  logic            sel_inner, inner_q;
  logic [DW-1:0]   sel_tgt, tgt_q, mar_q;
  logic [GS_W-1:0] gs_q;
  logic [ITW-1:0]  max_q;
  logic [1:0]      lvl_q;
  logic            in_win, at_limit, done_q, fail_q;
  logic            accept, pls_fire, rd_fire, rsp_fire;

  mlc_level_sel #(
    .CW(CW), .DW(DW), .WW(WW), .RST_CODE(RST_CODE), .SET_CODE(SET_CODE),
    .RST_W(RST_W), .SET_W(SET_W), .MELT_W(MELT_W)
  ) u_sel (
    .level   (target_lvl),
    .l1_tgt  (lvl1_tgt),
    .l2_tgt  (lvl2_tgt),
    .l1_init (lvl1_init),
    .l2_init (lvl2_init),
    .kind    (sel_kind),
    .code    (sel_code),
    .width   (sel_width),
    .inner   (sel_inner),
    .tgt     (sel_tgt)
  );

  mlc_step_calc #(.CW(CW), .DW(DW)) u_step (
    .cur_code  (code_q),
    .sample    (rd_rsp_data),
    .tgt       (tgt_q),
    .margin    (mar_q),
    .shift     (gs_q),
    .in_win    (in_win),
    .next_code (nxt_code)
  );

  mlc_iter_ctr #(.ITW(ITW), .DEF_ITER(DEF_ITER)) u_iter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .inc      (pls_fire),
    .limit_in (max_q),
    .count    (iter_count),
    .at_limit (at_limit)
  );

  assign accept       = (state == ST_IDLE) && start;
  assign pls_valid    = (state == ST_PULSE);
  assign rd_req_valid = (state == ST_RDREQ);
  assign rd_rsp_ready = (state == ST_WAIT);
  assign pls_fire     = pls_valid && pls_ready;
  assign rd_fire      = rd_req_valid && rd_req_ready;
  assign rsp_fire     = rd_rsp_ready && rd_rsp_valid;
  assign pls_kind     = kind_q;
  assign pls_current  = code_q;
  assign pls_width    = width_q;
  assign busy         = (state != ST_IDLE);
  assign done         = done_q;
  assign fail         = fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind_q  <= PK_AMORPH;
      code_q  <= '0;
      width_q <= '0;
      inner_q <= 1'b0;
      tgt_q   <= '0;
      mar_q   <= '0;
      gs_q    <= '0;
      max_q   <= '0;
      lvl_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            lvl_q   <= target_lvl;
            kind_q  <= sel_kind;
            code_q  <= sel_code;
            width_q <= sel_width;
            inner_q <= sel_inner;
            tgt_q   <= sel_tgt;
            mar_q   <= tol_margin;
            gs_q    <= gain_shift;
            max_q   <= max_iter;
            fail_q  <= 1'b0;
            state   <= ST_PULSE;
          end
        end
        ST_PULSE: begin
          if (pls_ready) begin
            if (inner_q) state <= ST_RDREQ;
            else begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        ST_RDREQ: begin
          if (rd_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_rsp_valid) begin
            if (in_win) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else if (at_limit) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
              fail_q <= 1'b1;
            end else begin
              code_q <= nxt_code;
              state  <= ST_PULSE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: stalled requests keep valid and payload frozen
  a_r8_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pls_valid && !pls_ready) |=>
      (pls_valid && $stable(pls_kind) && $stable(pls_current) && $stable(pls_width)));

  a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> rd_req_valid);

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pls_valid, rd_req_valid, rd_rsp_ready}));

  // R1, R2: outer levels never request a verify read
  a_r1_outer_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (lvl_q == 2'd1 || lvl_q == 2'd2));

  // R3: a read request follows directly on an accepted melt pulse
  a_r3_read_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pls_fire && inner_q) |=> rd_req_valid);

  // R9: a start during a run leaves the latched level untouched
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(lvl_q));

  // R10: done is a single-cycle strobe and is never raised while busy
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/mlc_prog_ctrl_bench.sv
module mlc_prog_ctrl_bench;

  localparam int CW = 8;
  localparam int DW = 8;
  localparam int WW = 8;
  localparam int ITW = 6;

  typedef struct packed {
    logic [1:0]  lvl;
    logic [7:0]  tgt;
    logic [7:0]  mar;
    logic [7:0]  init;
    logic [2:0]  gs;
    logic [5:0]  maxi;
    logic [5:0]  e_iter;
    logic        e_fail;
    logic [7:0]  e_code;
    logic [1:0]  e_kind;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{lvl:2'd0, tgt:8'd83,  mar:8'd6, init:8'd100, gs:3'd1, maxi:6'd0, e_iter:6'd1,  e_fail:1'b0, e_code:8'd255, e_kind:2'd0},
    '{lvl:2'd3, tgt:8'd83,  mar:8'd6, init:8'd100, gs:3'd1, maxi:6'd0, e_iter:6'd1,  e_fail:1'b0, e_code:8'd40,  e_kind:2'd1},
    '{lvl:2'd1, tgt:8'd83,  mar:8'd6, init:8'd100, gs:3'd1, maxi:6'd0, e_iter:6'd3,  e_fail:1'b0, e_code:8'd112, e_kind:2'd2},
    '{lvl:2'd2, tgt:8'd128, mar:8'd6, init:8'd40,  gs:3'd1, maxi:6'd0, e_iter:6'd4,  e_fail:1'b0, e_code:8'd68,  e_kind:2'd2},
    '{lvl:2'd2, tgt:8'd128, mar:8'd6, init:8'd100, gs:3'd0, maxi:6'd0, e_iter:6'd2,  e_fail:1'b0, e_code:8'd72,  e_kind:2'd2},
    '{lvl:2'd1, tgt:8'd83,  mar:8'd6, init:8'd100, gs:3'd7, maxi:6'd3, e_iter:6'd3,  e_fail:1'b1, e_code:8'd102, e_kind:2'd2},
    '{lvl:2'd1, tgt:8'd83,  mar:8'd6, init:8'd0,   gs:3'd7, maxi:6'd0, e_iter:6'd16, e_fail:1'b1, e_code:8'd15,  e_kind:2'd2},
    '{lvl:2'd2, tgt:8'd250, mar:8'd2, init:8'd20,  gs:3'd0, maxi:6'd3, e_iter:6'd3,  e_fail:1'b1, e_code:8'd0,   e_kind:2'd2},
    '{lvl:2'd1, tgt:8'd3,   mar:8'd6, init:8'd195, gs:3'd0, maxi:6'd0, e_iter:6'd1,  e_fail:1'b0, e_code:8'd195, e_kind:2'd2}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [1:0]     target_lvl = '0;
  logic [DW-1:0]  lvl1_tgt = '0, lvl2_tgt = '0, tol_margin = '0;
  logic [CW-1:0]  lvl1_init = '0, lvl2_init = '0;
  logic [2:0]     gain_shift = '0;
  logic [ITW-1:0] max_iter = '0;
  logic           busy, done, fail;
  logic [ITW-1:0] iter_count;
  logic           pls_valid, pls_ready;
  logic [1:0]     pls_kind;
  logic [CW-1:0]  pls_current;
  logic [WW-1:0]  pls_width;
  logic           rd_req_valid, rd_req_ready;
  logic           rd_rsp_valid, rd_rsp_ready;
  logic [DW-1:0]  rd_rsp_data;

  int checks = 0;
  int fails  = 0;
  int n_pls = 0, n_rd = 0;
  int first_code = 0, last_code = 0, last_kind = 0, last_width = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mlc_prog_ctrl u_mlc_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .target_lvl(target_lvl),
    .lvl1_tgt(lvl1_tgt), .lvl2_tgt(lvl2_tgt), .tol_margin(tol_margin),
    .lvl1_init(lvl1_init), .lvl2_init(lvl2_init), .gain_shift(gain_shift),
    .max_iter(max_iter), .busy(busy), .done(done), .fail(fail),
    .iter_count(iter_count), .pls_valid(pls_valid), .pls_ready(pls_ready),
    .pls_kind(pls_kind), .pls_current(pls_current), .pls_width(pls_width),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data)
  );

  function automatic logic [7:0] cell_read(int code);
    return (code >= 200) ? 8'd0 : 8'(200 - code);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Peers: ready toggles each cycle; sample returned two cycles after a read
  initial begin
    bit phase = 1'b0;
    int pend = 0;
    pls_ready = 1'b0;
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0;
    rd_rsp_data = '0;
    forever begin
      @(negedge clk);
      phase = ~phase;
      rd_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data = cell_read(last_code);
        end
      end
      pls_ready = phase;
      rd_req_ready = phase;
      if (pls_valid && pls_ready) begin
        if (n_pls == 0) first_code = int'(pls_current);
        n_pls++;
        last_code = int'(pls_current);
        last_kind = int'(pls_kind);
        last_width = int'(pls_width);
      end
      if (rd_req_valid && rd_req_ready) begin
        n_rd++;
        pend = 2;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  task automatic setup(vec_t v);
    lvl1_tgt = v.tgt; lvl2_tgt = v.tgt; tol_margin = v.mar;
    lvl1_init = v.init; lvl2_init = v.init;
    gain_shift = v.gs; max_iter = v.maxi;
  endtask

  task automatic kick(logic [1:0] lvl);
    n_pls = 0; n_rd = 0;
    @(negedge clk);
    start = 1'b1; target_lvl = lvl;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic check_result(vec_t v);
    int exp_first, exp_w, exp_rd;
    exp_first = (v.lvl == 2'd0) ? 255 : (v.lvl == 2'd3) ? 40 : int'(v.init);
    exp_w     = (v.lvl == 2'd0) ? 4 : (v.lvl == 2'd3) ? 60 : 8;
    exp_rd    = (v.lvl == 2'd1 || v.lvl == 2'd2) ? int'(v.e_iter) : 0;
    chk(done == 1'b1, "R10 done seen", int'(done), 1);
    chk(busy == 1'b0, "R10 idle at done", int'(busy), 0);
    chk(fail == v.e_fail, "R4/R6 fail flag", int'(fail), int'(v.e_fail));
    chk(iter_count == v.e_iter, "R7 iter_count", int'(iter_count), int'(v.e_iter));
    chk(n_pls == int'(v.e_iter), "R6 pulses issued", n_pls, int'(v.e_iter));
    chk(n_rd == exp_rd, "R3 reads per pulse", n_rd, exp_rd);
    chk(first_code == exp_first, "R3 first current", first_code, exp_first);
    chk(last_code == int'(v.e_code), "R5 last current", last_code, int'(v.e_code));
    chk(last_kind == int'(v.e_kind), "R1/R2 pulse kind", last_kind, int'(v.e_kind));
    chk(last_width == exp_w, "R1/R2 pulse width", last_width, exp_w);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(iter_count == v.e_iter, "R7 count held", int'(iter_count), int'(v.e_iter));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R10 reset done", int'(done), 0);
    chk(pls_valid == 1'b0, "R8 reset pulse valid", int'(pls_valid), 0);
    chk(rd_req_valid == 1'b0, "R8 reset read valid", int'(rd_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i]);
      kick(VECS[i].lvl);
      wait_done();
      check_result(VECS[i]);
    end

    // R9: start for level 0 raised mid-run is ignored
    setup(VECS[3]);
    kick(VECS[3].lvl);
    while (n_pls < 1) @(negedge clk);
    start = 1'b1; target_lvl = 2'd0;
    lvl2_init = 8'd5;
    @(negedge clk);
    start = 1'b0;
    lvl2_init = VECS[3].init;
    wait_done();
    chk(n_pls == 4, "R9 busy start ignored pulses", n_pls, 4);
    check_result(VECS[3]);

    // R8: reset mid-run drops all requests
    setup(VECS[6]);
    kick(VECS[6].lvl);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(pls_valid == 1'b0 && rd_req_valid == 1'b0, "R8 reset clears requests",
        int'(pls_valid | rd_req_valid), 0);
    chk(busy == 1'b0, "R10 reset clears busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    finish_run();
  end

endmodule